// File: doc/BRIEF.md
# DMA Graceful Stop and Ring Poll Controller

This block holds the DMA control word and the per-ring halt status of a multi-ring Ethernet controller. It turns register writes into two kinds of output. The first is a one-cycle walk request to the descriptor engine of each transmit or receive ring. The second is a stop-complete event for the interrupt logic. A graceful stop request completes at once when its direction is idle. When a frame is in flight, completion waits for that frame to end.

A free-running poll timer asks transmit ring 0 to rescan its descriptors at a fixed interval. Polling is armed by a control write that leaves the wait bit clear. It is suppressed while the transmit stop bit is set, and it ends at the first expiry after the wait bit is set. The period is given in poll ticks. With the tick tied high, the period is in clock cycles. The descriptor engines report halted rings through set inputs, and software clears those flags with write-one-to-clear writes.

Top module: `dma_stop_poll`

## Requirements
- R1: After reset all walk requests and stop events are low, all halt flags are 0, and no poll walk is requested until the control register is written.
- R2: A write with `wr_sel`=0 and data bit 0 (receive stop) set while `rx_busy` is low, or while `rx_done` is high in the same cycle, pulses `rx_stop_done` for one cycle in the cycle after the write.
- R3: If `rx_busy` is high and `rx_done` low at such a write, `rx_stop_done` stays low. It pulses one cycle after the next `rx_done`, unless a later control write clears bit 0 first. An `rx_done` with no pending request gives no event.
- R4: Control data bit 1 (transmit stop) behaves as in R2 and R3, using `tx_busy`, `tx_done` and `tx_stop_done`.
- R5: A control write with data bit 2 (wait) clear restarts the poll timer. With `poll_tick` high, `tx_walk[0]` then pulses POLL_TICKS cycles after the write, and again every POLL_TICKS cycles.
- R6: At an expiry while control bit 1 is set, no walk is requested.
- R7: At an expiry while control bit 2 is set, no walk is requested and polling ends until the next restart.
- R8: The poll timer advances only in cycles where `poll_tick` is high.
- R9: A write with `wr_sel`=1 requests a walk of transmit ring i for each data bit (31-i) that is set, whatever the halt state. All requests from one write pulse together, one cycle after the write. Other data bits have no effect.
- R10: A write with `wr_sel`=2 requests a walk of receive ring i only when data bit (23-i) is set and `rx_halt[i]` was already 1.
- R11: In both status registers a written one clears the halt flag after the walk decision. A `*_halt_set` bit sets its flag, and a set wins over a clear in the same cycle.
- R12: A poll expiry and a transmit status write for ring 0 in the same cycle give one merged pulse on `tx_walk[0]`, and the poll rhythm is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | 0 control, 1 transmit status, 2 receive status, 3 none |
| wr_data | input | 32 | Write data |
| rx_busy | input | 1 | Receive frame in progress |
| tx_busy | input | 1 | Transmit frame in progress |
| rx_done | input | 1 | Receive frame ended (pulse) |
| tx_done | input | 1 | Transmit frame ended (pulse) |
| poll_tick | input | 1 | Poll timer advance enable |
| tx_halt_set | input | NRING | Transmit ring halted (pulse per ring) |
| rx_halt_set | input | NRING | Receive ring halted (pulse per ring) |
| tx_walk | output | NRING | Transmit ring walk request pulses |
| rx_walk | output | NRING | Receive ring walk request pulses |
| rx_stop_done | output | 1 | Receive graceful stop complete event |
| tx_stop_done | output | 1 | Transmit graceful stop complete event |
| tx_halt | output | NRING | Transmit halt flags |
| rx_halt | output | NRING | Receive halt flags |

## Verification
The poll expiry and a software halt-clear write both drive `tx_walk[0]`, so they can fall in the same cycle. The bench restarts the timer and counts cycles. In the exact expiry cycle it writes the transmit status register with rings 0 and 1 selected. It then expects one combined pulse on both rings, silence in the following cycle, and the next poll pulse still POLL_TICKS cycles after the first. A second coincidence, a stop write in the same cycle as frame end, is expected to complete the stop at once.

// File: rtl/dma_stop_poll_pkg.sv
package dma_stop_poll_pkg;
   localparam int REG_W = 32;

   typedef enum logic [1:0] {
      SEL_CTRL   = 2'd0,
      SEL_TXHALT = 2'd1,
      SEL_RXHALT = 2'd2,
      SEL_NONE   = 2'd3
   } reg_sel_e;

   // control word bit positions
   localparam int CTL_RX_STOP = 0;
   localparam int CTL_TX_STOP = 1;
   localparam int CTL_WAIT    = 2;

   // halt flag of ring i sits at TOP - i
   localparam int TXH_TOP = 31;
   localparam int RXH_TOP = 23;
   localparam int MAX_RINGS = 8;

   typedef struct packed {
      logic wait_poll;
      logic tx_stop;
      logic rx_stop;
   } ctl_t;
endpackage

// File: rtl/dma_stop_poll_stopper.sv
module dma_stop_poll_stopper (
   input  logic clk,
   input  logic rst_n,
   input  logic ctl_wr,
   input  logic req_bit,
   input  logic busy,
   input  logic done,
   output logic evt_o
);
   logic pend_q;
   logic fire_now;
   logic fire_late;
   logic evt_q;

   // request seen while idle, or in the very cycle the frame closes
   assign fire_now  = ctl_wr && req_bit && (!busy || done);
   // deferred request completes at frame end unless withdrawn this cycle
   assign fire_late = pend_q && done && !(ctl_wr && !req_bit);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         evt_q  <= 1'b0;
      end else begin
         evt_q <= fire_now || fire_late;
         if (ctl_wr)
            pend_q <= req_bit && busy && !done;
         else if (done)
            pend_q <= 1'b0;
      end
   end

   assign evt_o = evt_q;
endmodule

// File: rtl/dma_stop_poll_timer.sv
module dma_stop_poll_timer #(
   parameter int POLL_TICKS = 1000000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic tick,
   input  logic wait_q,
   input  logic hold_q,
   output logic fire_o
);
   localparam int CNT_W = (POLL_TICKS > 2) ? $clog2(POLL_TICKS) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(POLL_TICKS - 1);

   if (POLL_TICKS < 2) begin : g_bad_period
      $error("dma_stop_poll_timer: POLL_TICKS must be at least 2");
   end

   logic             run_q;
   logic [CNT_W-1:0] cnt_q;
   logic             expire;

   assign expire = run_q && tick && (cnt_q == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         cnt_q <= '0;
      end else if (restart) begin
         run_q <= 1'b1;
         cnt_q <= '0;
      end else if (expire) begin
         cnt_q <= '0;
         if (wait_q)
            run_q <= 1'b0;
      end else if (run_q && tick) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // a restart in the same cycle discards the expiry
   assign fire_o = expire && !restart && !wait_q && !hold_q;
endmodule

// File: rtl/dma_stop_poll_halt_bank.sv
module dma_stop_poll_halt_bank #(
   parameter int NRING      = 8,
   parameter bit NEED_HALT  = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [NRING-1:0] field,
   input  logic [NRING-1:0] set_i,
   output logic [NRING-1:0] walk_o,
   output logic [NRING-1:0] halt_o
);
   logic [NRING-1:0] halt_q;
   logic [NRING-1:0] clr;

   for (genvar g = 0; g < NRING; g++) begin : g_ring
      assign clr[g] = wr && field[g];
      if (NEED_HALT) begin : g_gated
         assign walk_o[g] = clr[g] && halt_q[g];
      end else begin : g_plain
         assign walk_o[g] = clr[g];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         halt_q <= '0;
      else
         halt_q <= (halt_q & ~clr) | set_i;
   end

   assign halt_o = halt_q;
endmodule

// File: rtl/dma_stop_poll.sv
module dma_stop_poll
   import dma_stop_poll_pkg::*;
#(
   parameter int NRING      = 8,
   parameter int POLL_TICKS = 1000000
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [1:0]           wr_sel,
   input  logic [REG_W-1:0]     wr_data,
   input  logic                 rx_busy,
   input  logic                 tx_busy,
   input  logic                 rx_done,
   input  logic                 tx_done,
   input  logic                 poll_tick,
   input  logic [NRING-1:0]     tx_halt_set,
   input  logic [NRING-1:0]     rx_halt_set,
   output logic [NRING-1:0]     tx_walk,
   output logic [NRING-1:0]     rx_walk,
   output logic                 rx_stop_done,
   output logic                 tx_stop_done,
   output logic [NRING-1:0]     tx_halt,
   output logic [NRING-1:0]     rx_halt
);
   if (NRING < 1 || NRING > MAX_RINGS) begin : g_bad_rings
      $error("dma_stop_poll: NRING out of range");
   end

   logic ctl_wr, txh_wr, rxh_wr;
   ctl_t ctl_q, ctl_new;
   logic [NRING-1:0] txh_field, rxh_field;
   logic [NRING-1:0] txh_walk, rxh_walk;
   logic [NRING-1:0] poll_vec;
   logic [NRING-1:0] tx_walk_q, rx_walk_q;
   logic             poll_fire;
   logic             unused_bits;

   assign ctl_wr = wr_en && (wr_sel == SEL_CTRL);
   assign txh_wr = wr_en && (wr_sel == SEL_TXHALT);
   assign rxh_wr = wr_en && (wr_sel == SEL_RXHALT) && (wr_sel != SEL_NONE);
   assign unused_bits = ^wr_data;

   assign ctl_new.rx_stop   = wr_data[CTL_RX_STOP];
   assign ctl_new.tx_stop   = wr_data[CTL_TX_STOP];
   assign ctl_new.wait_poll = wr_data[CTL_WAIT];

   always_ff @(posedge clk) begin
      if (!rst_n)
         ctl_q <= '0;
      else if (ctl_wr)
         ctl_q <= ctl_new;
   end

   // ring i maps to a descending bit position
   for (genvar g = 0; g < NRING; g++) begin : g_map
      assign txh_field[g] = wr_data[TXH_TOP - g];
      assign rxh_field[g] = wr_data[RXH_TOP - g];
   end

   dma_stop_poll_stopper u_rx_stop (
      .clk     (clk),
      .rst_n   (rst_n),
      .ctl_wr  (ctl_wr),
      .req_bit (ctl_new.rx_stop),
      .busy    (rx_busy),
      .done    (rx_done),
      .evt_o   (rx_stop_done)
   );

   dma_stop_poll_stopper u_tx_stop (
      .clk     (clk),
      .rst_n   (rst_n),
      .ctl_wr  (ctl_wr),
      .req_bit (ctl_new.tx_stop),
      .busy    (tx_busy),
      .done    (tx_done),
      .evt_o   (tx_stop_done)
   );

   dma_stop_poll_timer #(.POLL_TICKS(POLL_TICKS)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (ctl_wr && !ctl_new.wait_poll),
      .tick    (poll_tick),
      .wait_q  (ctl_q.wait_poll),
      .hold_q  (ctl_q.tx_stop),
      .fire_o  (poll_fire)
   );

   dma_stop_poll_halt_bank #(.NRING(NRING), .NEED_HALT(1'b0)) u_tx_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr     (txh_wr),
      .field  (txh_field),
      .set_i  (tx_halt_set),
      .walk_o (txh_walk),
      .halt_o (tx_halt)
   );

   dma_stop_poll_halt_bank #(.NRING(NRING), .NEED_HALT(1'b1)) u_rx_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr     (rxh_wr),
      .field  (rxh_field),
      .set_i  (rx_halt_set),
      .walk_o (rxh_walk),
      .halt_o (rx_halt)
   );

   assign poll_vec = NRING'(poll_fire);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_walk_q <= '0;
         rx_walk_q <= '0;
      end else begin
         tx_walk_q <= txh_walk | poll_vec;
         rx_walk_q <= rxh_walk;
      end
   end

   assign tx_walk = tx_walk_q;
   assign rx_walk = rx_walk_q;
endmodule

// File: rtl/dma_stop_poll_chk.sv
module dma_stop_poll_chk #(
   parameter int NRING      = 8,
   parameter int POLL_TICKS = 1000000
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [1:0]       wr_sel,
   input logic [31:0]      wr_data,
   input logic             rx_busy,
   input logic             tx_busy,
   input logic             rx_done,
   input logic             tx_done,
   input logic [NRING-1:0] tx_halt_set,
   input logic [NRING-1:0] tx_walk,
   input logic [NRING-1:0] rx_walk,
   input logic             rx_stop_done,
   input logic             tx_stop_done,
   input logic [NRING-1:0] tx_halt,
   input logic [NRING-1:0] rx_halt
);
   logic unused_chk;
   assign unused_chk = ^{wr_data, tx_halt_set, tx_walk, rx_walk, tx_halt, rx_halt, POLL_TICKS[0]};

   p_rx_stop_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == 2'd0 && wr_data[0] && (!rx_busy || rx_done)) |=> rx_stop_done);

   p_tx_stop_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == 2'd0 && wr_data[1] && (!tx_busy || tx_done)) |=> tx_stop_done);

   p_tx_walk_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == 2'd1 && wr_data[31]) |=> tx_walk[0]);

   p_rx_walk_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == 2'd2 && wr_data[23] && !rx_halt[0]) |=> !rx_walk[0]);

   p_rx_walk_had_halt_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rx_walk[0] |-> $past(rx_halt[0]));

   p_tx_w1c_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == 2'd1 && wr_data[31] && !tx_halt_set[0]) |=> !tx_halt[0]);
endmodule

bind dma_stop_poll dma_stop_poll_chk #(.NRING(NRING), .POLL_TICKS(POLL_TICKS)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .wr_en        (wr_en),
   .wr_sel       (wr_sel),
   .wr_data      (wr_data),
   .rx_busy      (rx_busy),
   .tx_busy      (tx_busy),
   .rx_done      (rx_done),
   .tx_done      (tx_done),
   .tx_halt_set  (tx_halt_set),
   .tx_walk      (tx_walk),
   .rx_walk      (rx_walk),
   .rx_stop_done (rx_stop_done),
   .tx_stop_done (tx_stop_done),
   .tx_halt      (tx_halt),
   .rx_halt      (rx_halt)
);

// File: tb/dma_stop_poll_bench.sv
`timescale 1ns/100ps
module dma_stop_poll_bench;
   localparam int NR = 4;
   localparam int NP = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [1:0]    wr_sel = 2'd3;
   logic [31:0]   wr_data = '0;
   logic          rx_busy = 1'b0, tx_busy = 1'b0, rx_done = 1'b0, tx_done = 1'b0;
   logic          poll_tick = 1'b1;
   logic [NR-1:0] tx_halt_set = '0, rx_halt_set = '0;
   logic [NR-1:0] tx_walk, rx_walk, tx_halt, rx_halt;
   logic          rx_stop_done, tx_stop_done;
   int            checks = 0;
   int            failures = 0;
   bit            finished = 1'b0;

   always #2.5 clk = ~clk;

   dma_stop_poll #(.NRING(NR), .POLL_TICKS(NP)) u_dma_stop_poll (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .rx_busy(rx_busy), .tx_busy(tx_busy), .rx_done(rx_done), .tx_done(tx_done),
      .poll_tick(poll_tick), .tx_halt_set(tx_halt_set), .rx_halt_set(rx_halt_set),
      .tx_walk(tx_walk), .rx_walk(rx_walk), .rx_stop_done(rx_stop_done),
      .tx_stop_done(tx_stop_done), .tx_halt(tx_halt), .rx_halt(rx_halt));

   task automatic check(input string req, input string what, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] place(input logic [NR-1:0] w, input int top);
      logic [31:0] d = '0;
      for (int i = 0; i < NR; i++) d[top - i] = w[i];
      return d;
   endfunction

   // called at a negedge; returns at the negedge after the write edge
   task automatic wr(input logic [1:0] sel, input logic [31:0] d);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_sel = 2'd3; wr_data = '0;
   endtask

   task automatic poll_run(input int kf, input int kl, input int lo, input int hi,
                           input int e1, input int e2, input string req);
      for (int k = kf; k <= kl; k++) begin
         poll_tick = !(k >= lo && k <= hi);
         @(negedge clk);
         check(req, $sformatf("poll walk k=%0d", k), 32'(tx_walk[0]), 32'(k == e1 || k == e2));
      end
      poll_tick = 1'b1;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         failures++;
         $display("FAIL R1 watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state and no polling before any control write
      check("R1", "tx_walk", 32'(tx_walk), 0);
      check("R1", "rx_walk", 32'(rx_walk), 0);
      check("R1", "stop events", 32'({rx_stop_done, tx_stop_done}), 0);
      check("R1", "halt flags", 32'({tx_halt, rx_halt}), 0);
      for (int k = 0; k < 3 * NP; k++) begin
         @(negedge clk);
         check("R1", "idle walk", 32'({tx_walk, rx_walk}), 0);
      end

      // R2 idle receive stop
      wr(2'd0, 32'h5);
      check("R2", "rx_stop_done", 32'(rx_stop_done), 1);
      check("R2", "tx_stop_done", 32'(tx_stop_done), 0);
      @(negedge clk);
      check("R2", "rx_stop_done one cycle", 32'(rx_stop_done), 0);
      // R2 busy but frame ends in the write cycle
      rx_busy = 1'b1; rx_done = 1'b1;
      wr(2'd0, 32'h5);
      rx_done = 1'b0; rx_busy = 1'b0;
      check("R2", "rx stop at frame end cycle", 32'(rx_stop_done), 1);

      // R3 deferred receive stop
      rx_busy = 1'b1;
      wr(2'd0, 32'h5);
      check("R3", "deferred no event", 32'(rx_stop_done), 0);
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         check("R3", "still busy", 32'(rx_stop_done), 0);
      end
      rx_done = 1'b1;
      @(negedge clk);
      rx_done = 1'b0; rx_busy = 1'b0;
      check("R3", "event at frame end", 32'(rx_stop_done), 1);
      @(negedge clk);
      check("R3", "event one cycle", 32'(rx_stop_done), 0);
      // R3 withdrawn request and done without request
      rx_busy = 1'b1;
      wr(2'd0, 32'h5);
      wr(2'd0, 32'h4);
      rx_done = 1'b1;
      @(negedge clk);
      rx_done = 1'b0; rx_busy = 1'b0;
      check("R3", "withdrawn no event", 32'(rx_stop_done), 0);
      rx_done = 1'b1;
      @(negedge clk);
      rx_done = 1'b0;
      check("R3", "done without request", 32'(rx_stop_done), 0);

      // R4 transmit stop, idle and deferred
      wr(2'd0, 32'h6);
      check("R4", "tx idle event", 32'(tx_stop_done), 1);
      check("R4", "rx no event", 32'(rx_stop_done), 0);
      tx_busy = 1'b1;
      wr(2'd0, 32'h6);
      check("R4", "tx deferred", 32'(tx_stop_done), 0);
      @(negedge clk);
      check("R4", "tx still busy", 32'(tx_stop_done), 0);
      tx_done = 1'b1;
      @(negedge clk);
      tx_done = 1'b0; tx_busy = 1'b0;
      check("R4", "tx at frame end", 32'(tx_stop_done), 1);

      // R5 polling rhythm
      wr(2'd0, 32'h0);
      check("R5", "no walk at write", 32'(tx_walk[0]), 0);
      poll_run(1, 2 * NP + 2, 1, 0, NP, 2 * NP, "R5");
      // R8 tick gaps stretch the period
      wr(2'd0, 32'h0);
      poll_run(1, NP + 14, 4, 13, NP + 10, -1, "R8");
      // R6 transmit stop suppresses poll walks
      wr(2'd0, 32'h2);
      check("R4", "tx stop idle", 32'(tx_stop_done), 1);
      poll_run(1, 3 * NP, 1, 0, -1, -1, "R6");
      // R7 wait bit ends polling
      wr(2'd0, 32'h0);
      poll_run(1, NP, 1, 0, NP, -1, "R7");
      wr(2'd0, 32'h4);
      check("R7", "walk at wait write", 32'(tx_walk[0]), 0);
      poll_run(1, 3 * NP, 1, 0, -1, -1, "R7");
      wr(2'd0, 32'h0);
      poll_run(1, NP, 1, 0, NP, -1, "R5");

      // R12 poll expiry coincides with transmit status write
      wr(2'd0, 32'h0);
      poll_run(1, NP - 1, 1, 0, -1, -1, "R12");
      wr(2'd1, place(4'b0011, 31));
      check("R12", "merged walk", 32'(tx_walk), 32'h3);
      poll_run(NP + 1, 2 * NP, 1, 0, 2 * NP, -1, "R12");
      wr(2'd0, 32'h4);
      repeat (2 * NP) @(negedge clk);
      wr(2'd1, 32'hFFFF_FFFF);

      // R9 / R11 transmit sweep: state s, written field w
      for (int s = 0; s < 16; s++) begin
         for (int w = 0; w < 16; w++) begin
            wr(2'd1, 32'hFFFF_FFFF);
            tx_halt_set = NR'(s);
            @(negedge clk);
            tx_halt_set = '0;
            check("R11", "tx set", 32'(tx_halt), 32'(s));
            wr(2'd1, place(NR'(w), 31) | 32'h00FF_FFFF);
            check("R9", "tx walk", 32'(tx_walk), 32'(w));
            check("R9", "rx untouched", 32'(rx_walk), 0);
            check("R11", "tx w1c", 32'(tx_halt), 32'(s & ~w & 15));
         end
      end
      // R10 / R11 receive sweep
      for (int s = 0; s < 16; s++) begin
         for (int w = 0; w < 16; w++) begin
            wr(2'd2, 32'hFFFF_FFFF);
            rx_halt_set = NR'(s);
            @(negedge clk);
            rx_halt_set = '0;
            check("R11", "rx set", 32'(rx_halt), 32'(s));
            wr(2'd2, place(NR'(w), 23) | 32'hFF0F_FFFF);
            check("R10", "rx walk", 32'(rx_walk), 32'(s & w));
            check("R10", "tx untouched", 32'(tx_walk), 0);
            check("R11", "rx w1c", 32'(rx_halt), 32'(s & ~w & 15));
         end
      end
      // R11 set wins over clear in the same cycle
      wr(2'd2, 32'hFFFF_FFFF);
      rx_halt_set = 4'b0001;
      wr(2'd2, place(4'b0001, 23));
      rx_halt_set = '0;
      check("R11", "set wins", 32'(rx_halt), 1);
      check("R10", "no walk from fresh set", 32'(rx_walk), 0);

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule